// File: doc/BRIEF.md
# Converter Sample Output Formatter

This block sits between the digital core of a 10-bit sampling converter and its output bus. Each raw conversion code enters a short register pipeline. The last pipeline stage writes the word that is driven out. On the way into that stage the word can be reshaped in three ways. The most significant bit can be inverted. The nine lower bits can be inverted. The live data can be swapped for a fixed alternating pattern, which is used to test the bus in-circuit.

The two invert controls are independent of each other. Using them, one converter can deliver four formats: straight binary, inverted binary, offset two's complement, and inverted offset two's complement. The same two controls also reshape the test pattern.

A per-bit drive-enable vector goes to the pad ring. It is asserted only while the output-enable and chip-enable inputs are both active. Chip enable also acts as a standby control: while it is inactive, every register keeps its contents.

Top module: `sample_out_formatter`

## Requirements
- R1: A code present on `code_i` at rising edge N, with `ce_n` low, is visible on `data_o` after rising edge N+2 (three edges, counting the capture edge). Each later code follows one edge after the previous one.
- R2: With `tst_n` high and both invert controls low, `data_o` equals the delayed code unchanged (straight binary: 0 stays 0, 1023 stays 1023).
- R3: `lo_inv` high inverts bits 8 down to 0 of the output word and leaves bit 9 unchanged.
- R4: `hi_inv` high inverts bit 9 only. With `lo_inv` low this gives offset two's complement, so code 512 is output as 0.
- R5: With `tst_n` low, the output ignores the data and shows a fixed pattern in which even-numbered bits are 1 (value 341). The invert controls still apply: `lo_inv` gives 170, `hi_inv` gives 853, and both give 682.
- R6: A change of `tst_n`, `lo_inv` or `hi_inv` reaches `data_o` at the next rising edge. It is applied to the sample that moves into the output stage at that edge.
- R7: `drv_en_o` is all zeros in the same cycle that `oe_n` is high. It is all ones while `oe_n` and `ce_n` are both low.
- R8: While `ce_n` is high, `drv_en_o` is all zeros and neither `data_o` nor the pipeline changes, whatever the other inputs do. When `ce_n` returns low, the samples that were held continue to the output in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| code_i | input | 10 | Raw conversion code |
| tst_n | input | 1 | Low selects the fixed test pattern |
| lo_inv | input | 1 | High inverts bits 8..0 |
| hi_inv | input | 1 | High inverts bit 9 |
| oe_n | input | 1 | Low enables the output drivers |
| ce_n | input | 1 | Low means active; high means standby (pipeline holds, drivers off) |
| data_o | output | 10 | Formatted output word |
| drv_en_o | output | 10 | Per-bit driver enable, 1 = drive |

## Verification
Data results are due after the third rising edge, counting the edge that captures the code. Format-control results are due after the very next edge. Driver-enable results are due in the same cycle, with no edge in between.

The bench changes its inputs on the falling edge. It checks the enable vector one time unit after each change. It checks the data word on the falling edge that follows each rising edge. A running model counts only the edges with chip enable low, so a data comparison is made only once three active edges have filled the pipeline. Standby stretches are checked by confirming that the held word survives changes on every other input.

// File: rtl/sofmt_pkg.sv
package sofmt_pkg;
   typedef struct packed {
      logic pat_sel;   // 1 = show alternating test pattern
      logic inv_lo;    // invert bits below the MSB
      logic inv_hi;    // invert the MSB
   } sofmt_ctrl_t;

   // even-numbered bits set; sliced to the word width by users
   localparam logic [31:0] ALT_BITS = 32'h5555_5555;
   localparam int unsigned MAX_W    = 32;
endpackage

// File: rtl/sofmt_delay.sv
module sofmt_delay #(
   parameter int unsigned W      = 10,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         adv,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] stg [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk) begin
                  if (adv) stg[0] <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk) begin
                  if (adv) stg[i] <= stg[i-1];
               end
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sofmt_shaper.sv
module sofmt_shaper
   import sofmt_pkg::*;
#(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         adv,
   input  sofmt_ctrl_t  ctrl,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int unsigned LO_W = W - 1;
   localparam logic [W-1:0] PATTERN = ALT_BITS[W-1:0];

   logic [W-1:0] base;
   logic [W-1:0] flip;
   logic [W-1:0] shaped;

   always_comb begin
      base   = ctrl.pat_sel ? PATTERN : d;
      flip   = {ctrl.inv_hi, {LO_W{ctrl.inv_lo}}};
      shaped = base ^ flip;
   end

   always_ff @(posedge clk) begin
      if (adv) q <= shaped;
   end
endmodule

// File: rtl/sofmt_drive.sv
module sofmt_drive #(
   parameter int unsigned W = 10
) (
   input  logic         oe_n,
   input  logic         ce_n,
   output logic [W-1:0] en
);
   logic live;
   assign live = ~oe_n & ~ce_n;

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign en[b] = live;
      end
   endgenerate
endmodule

// File: rtl/sample_out_formatter.sv
module sample_out_formatter
   import sofmt_pkg::*;
#(
   parameter int unsigned W   = 10,
   parameter int unsigned LAT = 3
) (
   input  logic         clk,
   input  logic [W-1:0] code_i,
   input  logic         tst_n,
   input  logic         lo_inv,
   input  logic         hi_inv,
   input  logic         oe_n,
   input  logic         ce_n,
   output logic [W-1:0] data_o,
   output logic [W-1:0] drv_en_o
);
   localparam int unsigned RAW_STAGES = LAT - 1;

   generate
      if (W < 2 || W > MAX_W) begin : g_bad_w
         $error("sample_out_formatter: W must lie in 2..32");
      end
      if (LAT < 1) begin : g_bad_lat
         $error("sample_out_formatter: LAT must be at least 1");
      end
   endgenerate

   logic         adv;
   logic [W-1:0] raw_tail;
   sofmt_ctrl_t  ctrl;

   assign adv          = ~ce_n;
   assign ctrl.pat_sel = ~tst_n;
   assign ctrl.inv_lo  = lo_inv;
   assign ctrl.inv_hi  = hi_inv;

   sofmt_delay #(.W(W), .STAGES(RAW_STAGES)) u_delay (
      .clk (clk),
      .adv (adv),
      .d   (code_i),
      .q   (raw_tail)
   );

   sofmt_shaper #(.W(W)) u_shape (
      .clk  (clk),
      .adv  (adv),
      .ctrl (ctrl),
      .d    (raw_tail),
      .q    (data_o)
   );

   sofmt_drive #(.W(W)) u_drive (
      .oe_n (oe_n),
      .ce_n (ce_n),
      .en   (drv_en_o)
   );
endmodule

// File: rtl/sofmt_chk.sv
module sofmt_chk
   import sofmt_pkg::*;
#(
   parameter int unsigned W   = 10,
   parameter int unsigned LAT = 3
) (
   input logic         clk,
   input logic [W-1:0] code_i,
   input logic         tst_n,
   input logic         lo_inv,
   input logic         hi_inv,
   input logic         oe_n,
   input logic         ce_n,
   input logic [W-1:0] data_o,
   input logic [W-1:0] drv_en_o
);
   logic [1:0] warm = 2'd0;
   logic       ready;
   always_ff @(posedge clk) begin
      if (warm != 2'd3) warm <= warm + 2'd1;
   end
   assign ready = (warm == 2'd3);

   function automatic logic [W-1:0] expect_word(logic [W-1:0] c, logic t_n,
                                                logic lo, logic hi);
      logic [W-1:0] b;
      b = t_n ? c : ALT_BITS[W-1:0];
      return b ^ {hi, {(W-1){lo}}};
   endfunction

   generate
      if (LAT == 3) begin : g_lat3
         AST_PIPE_FORMAT: assert property (@(posedge clk) disable iff (!ready)
            (!$past(ce_n, 1) && !$past(ce_n, 2) && !$past(ce_n, 3)) |->
            data_o == expect_word($past(code_i, 3), $past(tst_n, 1),
                                  $past(lo_inv, 1), $past(hi_inv, 1))); // R1
      end
   endgenerate

   AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!ready)
      $past(ce_n) |-> $stable(data_o)); // R8

   AST_DRV_OFF_OE: assert property (@(posedge clk) disable iff (!ready)
      oe_n |-> (drv_en_o == '0)); // R7

   AST_DRV_OFF_CE: assert property (@(posedge clk) disable iff (!ready)
      ce_n |-> (drv_en_o == '0)); // R8

   AST_DRV_ON: assert property (@(posedge clk) disable iff (!ready)
      (!oe_n && !ce_n) |-> (&drv_en_o)); // R7

   AST_PATTERN_SHAPE: assert property (@(posedge clk) disable iff (!ready)
      (!$past(ce_n) && !$past(tst_n)) |->
      data_o == (ALT_BITS[W-1:0] ^ {$past(hi_inv), {(W-1){$past(lo_inv)}}})); // R5
endmodule

bind sample_out_formatter sofmt_chk #(.W(W), .LAT(LAT)) u_chk (.*);

// File: tb/sim_sample_out_formatter.sv
`timescale 1ns/1ps
module sim_sample_out_formatter;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic [W-1:0] code_i = '0;
   logic         tst_n = 1'b1, lo_inv = 1'b0, hi_inv = 1'b0;
   logic         oe_n = 1'b1, ce_n = 1'b1;
   logic [W-1:0] data_o, drv_en_o;

   int tests = 0;
   int fails = 0;

   // model state, built from the requirements
   logic [W-1:0] m1, m2, mo;
   int           nvalid = 0;

   always #5 clk = ~clk;

   sample_out_formatter #(.W(W), .LAT(3)) u0 (
      .clk(clk), .code_i(code_i), .tst_n(tst_n), .lo_inv(lo_inv),
      .hi_inv(hi_inv), .oe_n(oe_n), .ce_n(ce_n),
      .data_o(data_o), .drv_en_o(drv_en_o)
   );

   function automatic logic [W-1:0] fmt(logic [W-1:0] c, logic t_n, logic lo, logic hi);
      int v;
      v = t_n ? int'(c) : 341;
      if (lo) v = v ^ 511;
      if (hi) v = v ^ 512;
      return W'(v);
   endfunction

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // drive at falling edge, check enables, clock, check data after the edge
   task automatic step(string req, logic [W-1:0] c, logic t_n, logic lo,
                       logic hi, logic oe, logic ce);
      code_i = c; tst_n = t_n; lo_inv = lo; hi_inv = hi; oe_n = oe; ce_n = ce;
      #1;
      check(req, drv_en_o, (!oe && !ce) ? '1 : '0);
      @(posedge clk);
      if (!ce) begin
         mo = fmt(m2, t_n, lo, hi);
         m2 = m1;
         m1 = c;
         nvalid++;
      end
      @(negedge clk);
      if (nvalid >= 3) check(req, data_o, mo);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [W-1:0] held;
      @(negedge clk);
      // R8: standby at start keeps drivers off; R7 oe off too
      #1;
      check("R8 start", drv_en_o, '0);
      ce_n = 1'b0; #1;
      check("R7 oe high", drv_en_o, '0);
      ce_n = 1'b1;
      @(negedge clk);

      // R1: explicit latency count with a marker code
      step("R1 fill", 10'd0, 1, 0, 0, 0, 0);
      step("R1 fill", 10'd0, 1, 0, 0, 0, 0);
      step("R1 fill", 10'd0, 1, 0, 0, 0, 0);
      step("R1 mark", 10'h2A5, 1, 0, 0, 0, 0);
      step("R1 next", 10'd0, 1, 0, 0, 0, 0);
      check("R1 early", data_o, 10'd0);
      step("R1 next", 10'd0, 1, 0, 0, 0, 0);
      check("R1 due", data_o, 10'h2A5);

      // R2/R3/R4: exhaustive sweep of codes under every invert setting
      for (int inv = 0; inv < 4; inv++) begin
         for (int c = 0; c < 1024; c++) begin
            step(inv == 0 ? "R2 sweep" : (inv == 1 ? "R3 sweep" :
                 (inv == 2 ? "R4 sweep" : "R3 R4 sweep")),
                 W'(c), 1, inv[0], inv[1], 0, 0);
         end
      end
      // R2 endpoints, R4 offset two's complement midpoint
      step("R2", 10'd0, 1, 0, 0, 0, 0);
      step("R2", 10'd1023, 1, 0, 0, 0, 0);
      step("R2", 10'd512, 1, 0, 0, 0, 0);
      check("R2 zero", data_o, 10'd0);
      step("R4", 10'd0, 1, 0, 1, 0, 0);
      check("R2 top", data_o, 10'd1023 ^ 10'd512);
      step("R4", 10'd0, 1, 0, 1, 0, 0);
      check("R4 mid", data_o, 10'd0);

      // R5: test pattern under each invert combination
      step("R5", 10'd77, 0, 0, 0, 0, 0);
      check("R5 base", data_o, 10'd341);
      step("R5", 10'd99, 0, 1, 0, 0, 0);
      check("R5 lo", data_o, 10'd170);
      step("R5", 10'd5, 0, 0, 1, 0, 0);
      check("R5 hi", data_o, 10'd853);
      step("R5", 10'd6, 0, 1, 1, 0, 0);
      check("R5 both", data_o, 10'd682);

      // R6: controls flip on the very next edge while data keeps flowing
      for (int k = 0; k < 16; k++) begin
         step("R6 toggle", W'(k * 37), k[0], k[1], k[2], k[3], 0);
      end

      // R7: enable combinations
      step("R7 oe off", 10'd11, 1, 0, 0, 1, 0);
      step("R7 oe on", 10'd12, 1, 0, 0, 0, 0);

      // R8: standby holds data and pipeline, drivers off
      held = data_o;
      for (int k = 0; k < 6; k++) begin
         step("R8 standby", W'(900 - k), k[0], k[1], ~k[0], k[2], 1);
         check("R8 hold", data_o, held);
      end
      // resume: held samples 11 and 12 emerge in order
      step("R8 resume", 10'd13, 1, 0, 0, 0, 0);
      check("R8 first", data_o, 10'd11);
      step("R8 resume", 10'd14, 1, 0, 0, 0, 0);
      check("R8 second", data_o, 10'd12);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule